// File: doc/BRIEF.md
# Interrupt Alert GPIO Controller

This block collects four status sources into one sticky alert flag and drives a single open-drain general-purpose pin. The sources are the sampled level of the pin itself, a PLL lock indication, a headphone sense indication and a volume-at-minimum indication. Each source has its own enable bit. A host reaches the configuration through a small byte-wide register port. A status-read strobe acknowledges the alert.

The pin is configured by a direction bit and a two-bit mode field. The low mode bit selects the resting state: driven low, or released. The high mode bit arms a pulse. When an enabled source changes, the alert flag is set. If the pin is an armed output, it then flips to the opposite state for a fixed number of clocks. Because the pin is open-drain, the data line is always low and the output enable alone carries the pin state.

Top module: `alert_gpio_ctrl`

## Requirements
- R1: After synchronous reset both configuration registers read 0x00, `alert` is 0 and `gpio_oe` is 0.
- R2: Register select 0 holds the pin configuration byte: mode in bits 7:6, direction in bit 5 (1 = output), debounce select in bits 4:3, mono in bit 2 and zero-detect enable in bit 0. Bit 1 always reads 0.
- R3: Register select 1 holds the enable byte: pin-input enable in bit 6, lock enable in bit 5, headphone-sense enable in bit 4 and volume-minimum enable in bit 3. Bits 7 and 2:0 always read 0.
- R4: With direction 1 and no pulse running, mode bit 0 = 0 drives the pin low (`gpio_oe` = 1) and mode bit 0 = 1 releases it (`gpio_oe` = 0). `gpio_do` is always 0.
- R5: With direction 0, `gpio_oe` stays 0 whatever the mode and whatever alerts occur.
- R6: A level change on an enabled source sets `alert` after the third rising clock edge, counted from the first edge that samples the new level. The path is two synchroniser flops and then the alert register.
- R7: A change on a disabled source leaves `alert` unchanged. The pin-input source counts only while direction is 0.
- R8: `alert` stays set until `stat_rd` is sampled high. After that edge it reads 0, unless R9 applies.
- R9: If `stat_rd` coincides with a new enabled change, `alert` stays 1.
- R10: With direction 1 and mode bit 1 set, an enabled change inverts `gpio_oe` for exactly 16 cycles. The pulse starts at the same edge that sets `alert`.
- R11: An enabled change during a running pulse restarts the full 16-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pin configuration, 1 = interrupt enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| stat_rd | input | 1 | Status read; acknowledges the alert |
| gpio_in | input | 1 | Sampled pad level |
| pll_lock | input | 1 | PLL lock status |
| hp_sense | input | 1 | Headphone sense status |
| vol_min | input | 1 | Volume-at-minimum status |
| alert | output | 1 | Sticky alert flag |
| gpio_oe | output | 1 | Pin output enable (1 pulls low) |
| gpio_do | output | 1 | Pin output data, held low |
| cfg_debounce | output | 2 | Debounce select for a neighbouring block |
| cfg_mono | output | 1 | Mono select for a neighbouring block |
| cfg_zero_det | output | 1 | Zero-detect enable for a neighbouring block |

## Verification
The checker assumes that every status input is level-like. It also assumes that `stat_rd` is a single-cycle strobe, with no other ordering against the sources. The bench changes the status inputs only on falling edges and leaves at least three cycles between changes it measures. The exception is the restart case, where a second change lands inside a running pulse on purpose. Configuration writes are issued only while no change is in flight, so no pulse is armed or disarmed halfway through the synchroniser.

// File: rtl/alert_gpio_pkg.sv
package alert_gpio_pkg;

    localparam int NUM_SRC = 4;
    localparam int REG_W   = 8;

    // source index order in the change and enable vectors
    localparam int SRC_PIN  = 0;
    localparam int SRC_LOCK = 1;
    localparam int SRC_HPS  = 2;
    localparam int SRC_VMIN = 3;

    localparam logic [REG_W-1:0] PINCFG_MASK = 8'hFD;
    localparam logic [REG_W-1:0] IRQEN_MASK  = 8'h78;

    typedef struct packed {
        logic [1:0] mode;
        logic       dir_out;
        logic [1:0] debounce;
        logic       mono;
        logic       zero_bit;
        logic       zero_det;
    } pincfg_t;

    typedef struct packed {
        logic       rsv_hi;
        logic       en_pin;
        logic       en_lock;
        logic       en_hps;
        logic       en_vmin;
        logic [2:0] rsv_lo;
    } irqen_t;

    function automatic logic rest_low(input logic [1:0] mode);
        return ~mode[0];
    endfunction

    function automatic logic pulse_armed(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/ag_regs.sv
module ag_regs
    import alert_gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output pincfg_t          pincfg,
    output irqen_t           irqen
);
    logic [REG_W-1:0] pin_q, irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= '0;
            irq_q <= '0;
        end else if (we) begin
            if (!sel) pin_q <= wdata & PINCFG_MASK;
            else      irq_q <= wdata & IRQEN_MASK;
        end
    end

    assign pincfg = pincfg_t'(pin_q);
    assign irqen  = irqen_t'(irq_q);
    assign rdata  = sel ? irq_q : pin_q;

endmodule

// File: rtl/ag_sync.sv
module ag_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] chg
);
    logic [N-1:0] stage [STAGES];
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stage[STAGES-1];
    end

    assign chg = stage[STAGES-1] ^ prev;

endmodule

// File: rtl/ag_alert.sv
module ag_alert #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ack,
    input  logic pulse_en,
    output logic alert,
    output logic pulse_act
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            alert <= 1'b0;
            cnt   <= '0;
        end else begin
            alert <= evt | (alert & ~ack);
            if (evt && pulse_en)  cnt <= CW'(PULSE_LEN);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    assign pulse_act = (cnt != '0);

endmodule

// File: rtl/alert_gpio_ctrl.sv
module alert_gpio_ctrl
    import alert_gpio_pkg::*;
#(
    parameter int PULSE_LEN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             stat_rd,
    input  logic             gpio_in,
    input  logic             pll_lock,
    input  logic             hp_sense,
    input  logic             vol_min,
    output logic             alert,
    output logic             gpio_oe,
    output logic             gpio_do,
    output logic [1:0]       cfg_debounce,
    output logic             cfg_mono,
    output logic             cfg_zero_det
);
    pincfg_t          pincfg;
    irqen_t           irqen;
    logic [NUM_SRC-1:0] src, chg, en;
    logic             any_evt, pulse_act, pulse_en;

    ag_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .pincfg(pincfg), .irqen(irqen)
    );

    always_comb begin
        src           = '0;
        src[SRC_PIN]  = gpio_in;
        src[SRC_LOCK] = pll_lock;
        src[SRC_HPS]  = hp_sense;
        src[SRC_VMIN] = vol_min;
        en            = '0;
        en[SRC_PIN]   = irqen.en_pin & ~pincfg.dir_out;
        en[SRC_LOCK]  = irqen.en_lock;
        en[SRC_HPS]   = irqen.en_hps;
        en[SRC_VMIN]  = irqen.en_vmin;
    end

    ag_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(src), .chg(chg)
    );

    assign any_evt  = |(chg & en);
    assign pulse_en = pincfg.dir_out & pulse_armed(pincfg.mode);

    ag_alert #(.PULSE_LEN(PULSE_LEN)) u_alert (
        .clk(clk), .rst(rst), .evt(any_evt), .ack(stat_rd),
        .pulse_en(pulse_en), .alert(alert), .pulse_act(pulse_act)
    );

    // open drain: enable pulls the pad low, data never drives high
    assign gpio_oe      = pincfg.dir_out & (rest_low(pincfg.mode) ^ pulse_act);
    assign gpio_do      = 1'b0;
    assign cfg_debounce = pincfg.debounce;
    assign cfg_mono     = pincfg.mono;
    assign cfg_zero_det = pincfg.zero_det;

endmodule

// File: rtl/alert_gpio_chk.sv
module alert_gpio_chk (
    input logic       clk,
    input logic       rst,
    input logic       dir_out,
    input logic [1:0] mode,
    input logic       stat_rd,
    input logic       evt,
    input logic       alert,
    input logic       pulse_act,
    input logic       gpio_oe
);
    a_r8_alert_sticky: assert property (@(posedge clk) disable iff (rst)
        alert && !stat_rd |=> alert);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !evt |=> !alert);

    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        evt |=> alert);

    a_r5_input_released: assert property (@(posedge clk) disable iff (rst)
        !dir_out |-> !gpio_oe);

    a_r4_rest_level: assert property (@(posedge clk) disable iff (rst)
        dir_out && !pulse_act |-> gpio_oe == !mode[0]);

    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_act) |-> $past(evt) && $past(dir_out && mode[1]));

    a_r10_pulse_sets_alert: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_act) |-> alert);

endmodule

bind alert_gpio_ctrl alert_gpio_chk u_chk (
    .clk(clk), .rst(rst), .dir_out(pincfg.dir_out), .mode(pincfg.mode),
    .stat_rd(stat_rd), .evt(any_evt), .alert(alert),
    .pulse_act(pulse_act), .gpio_oe(gpio_oe)
);

// File: tb/alert_gpio_ctrl_test.sv
`timescale 1ns/1ps
module alert_gpio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we, reg_sel, stat_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic       gpio_in, pll_lock, hp_sense, vol_min;
    logic       alert, gpio_oe, gpio_do, cfg_mono, cfg_zero_det;
    logic [1:0] cfg_debounce;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alert_gpio_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_rd(stat_rd),
        .gpio_in(gpio_in), .pll_lock(pll_lock), .hp_sense(hp_sense),
        .vol_min(vol_min), .alert(alert), .gpio_oe(gpio_oe),
        .gpio_do(gpio_do), .cfg_debounce(cfg_debounce), .cfg_mono(cfg_mono),
        .cfg_zero_det(cfg_zero_det)
    );

    // {written byte, expected readback, expected gpio_oe}
    localparam logic [16:0] VEC [9] = '{
        {8'h00, 8'h00, 1'b0},
        {8'h20, 8'h20, 1'b1},
        {8'h60, 8'h60, 1'b0},
        {8'hA0, 8'hA0, 1'b1},
        {8'hE0, 8'hE0, 1'b0},
        {8'hC0, 8'hC0, 1'b0},
        {8'hFF, 8'hFD, 1'b0},
        {8'hBE, 8'hBC, 1'b1},
        {8'h5A, 8'h58, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic ack();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0; stat_rd = 1'b0;
        gpio_in = 1'b0; pll_lock = 1'b0; hp_sense = 1'b0; vol_min = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk("R1 pin cfg", reg_rdata, 8'h00);
        reg_sel = 1'b1; #0;
        chk("R1 enables", reg_rdata, 8'h00);
        chk("R1 alert", {7'd0, alert}, 8'd0);
        chk("R1 oe", {7'd0, gpio_oe}, 8'd0);

        // R2 / R4 / R5 static pin table
        for (int i = 0; i < 9; i++) begin
            wr(1'b0, VEC[i][16:9]);
            chk("R2 readback", reg_rdata, VEC[i][8:1]);
            chk("R4 R5 static oe", {7'd0, gpio_oe}, {7'd0, VEC[i][0]});
            chk("R4 data low", {7'd0, gpio_do}, 8'd0);
        end
        chk("R2 debounce field", {6'd0, cfg_debounce}, 8'd3);

        // R3 enable register layout
        wr(1'b1, 8'hFF);
        chk("R3 readback", reg_rdata, 8'h78);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);

        // R7 disabled source ignored
        hp_sense = 1'b1;
        tick(4);
        chk("R7 disabled source", {7'd0, alert}, 8'd0);

        // R6 latency
        wr(1'b1, 8'h10);
        hp_sense = 1'b0;
        tick(2);
        chk("R6 not before third edge", {7'd0, alert}, 8'd0);
        tick(1);
        chk("R6 set on third edge", {7'd0, alert}, 8'd1);

        // R8 sticky then cleared by read
        tick(10);
        chk("R8 sticky", {7'd0, alert}, 8'd1);
        ack();
        chk("R8 read clears", {7'd0, alert}, 8'd0);

        // R9 read coinciding with a new event
        wr(1'b1, 8'h08);
        vol_min = 1'b1;
        tick(3);
        chk("R6 vol source", {7'd0, alert}, 8'd1);
        vol_min = 1'b0;
        tick(2);
        ack();
        chk("R9 event beats read", {7'd0, alert}, 8'd1);
        ack();
        chk("R8 later read clears", {7'd0, alert}, 8'd0);

        // R7 pin source only counts as input
        wr(1'b0, 8'h20);
        wr(1'b1, 8'h40);
        gpio_in = 1'b1;
        tick(4);
        chk("R7 pin source as output", {7'd0, alert}, 8'd0);
        wr(1'b0, 8'h00);
        gpio_in = 1'b0;
        tick(3);
        chk("R7 pin source as input", {7'd0, alert}, 8'd1);
        ack();

        // R10 pulse from released state
        wr(1'b1, 8'h20);
        wr(1'b0, 8'hE0);
        chk("R4 released rest", {7'd0, gpio_oe}, 8'd0);
        pll_lock = 1'b1;
        tick(3);
        chk("R10 pulse start", {7'd0, gpio_oe}, 8'd1);
        tick(15);
        chk("R10 pulse cycle 16", {7'd0, gpio_oe}, 8'd1);
        tick(1);
        chk("R10 pulse end", {7'd0, gpio_oe}, 8'd0);

        // R11 restart during pulse
        pll_lock = 1'b0;
        tick(3);
        chk("R11 first pulse", {7'd0, gpio_oe}, 8'd1);
        tick(5);
        pll_lock = 1'b1;
        tick(3);
        tick(12);
        chk("R11 past first end", {7'd0, gpio_oe}, 8'd1);
        tick(3);
        chk("R11 restarted last cycle", {7'd0, gpio_oe}, 8'd1);
        tick(1);
        chk("R11 restarted end", {7'd0, gpio_oe}, 8'd0);
        ack();

        // R10 pulse from driven-low state
        wr(1'b0, 8'hA0);
        chk("R4 low rest", {7'd0, gpio_oe}, 8'd1);
        pll_lock = 1'b0;
        tick(3);
        chk("R10 inverted pulse", {7'd0, gpio_oe}, 8'd0);
        tick(16);
        chk("R10 back to low", {7'd0, gpio_oe}, 8'd1);
        ack();

        // R5 mode ignored while input
        wr(1'b0, 8'hC0);
        pll_lock = 1'b1;
        tick(3);
        chk("R5 alert as input", {7'd0, alert}, 8'd1);
        chk("R5 no pulse as input", {7'd0, gpio_oe}, 8'd0);
        tick(5);
        chk("R5 still released", {7'd0, gpio_oe}, 8'd0);

        done = 1'b1;
        finish_run();
    end

endmodule